// File: doc/BRIEF.md
# Lockable Set-Associative Read Cache

This block is a 16 KB read-only cache that sits between a processor load port and a 16-bit external memory bus. Storage is split into 8 segments. Each segment holds 64 lines of eight 32-bit words, and a line may sit in any of the 64 entries of its segment. A load is accepted when the cache is idle. A hit returns the word from the cache without touching memory. A miss first reads the whole 32-byte line over the narrow bus as sixteen half-word beats, then returns the requested word.

Lockdown is a single base value shared by all segments. Entries whose index is below the base are never chosen for replacement, so any line held there keeps hitting. To lock data in place, software holds the base at zero and loads the lines it wants, which land in the lowest entries in order. It then raises the base above them. Replacement within each segment is round-robin over the unlocked entries.

Top module: `lockable_read_cache`

## Requirements
- R1: After reset, reqReady is 1, respValid is 0 and memReq is 0, and every entry is invalid, so the first load to any line misses.
- R2: The byte address splits into tag = addr[31:8], segment = addr[7:5] and word index = addr[4:2]. Bits [1:0] are ignored. Lines that differ only in segment bits occupy independent storage.
- R3: On a miss, memReq is raised for exactly 16 accepted beats. Beat k uses memAddr = line base + 2k, in ascending order. memAddr holds steady while memAck is 0.
- R4: Each 32-bit word is assembled from two consecutive beats: the first beat fills bits [15:0] and the second fills bits [31:16].
- R5: After a miss, respValid is asserted for exactly one cycle and only after all 16 beats have been accepted. respData then carries the requested word.
- R6: On a hit, respValid rises in the second cycle after the accepting clock edge with the correct word, and memReq stays 0.
- R7: Each segment has its own victim pointer. With lockBase at 0, once a segment has been filled with 64 distinct lines, the next fill replaces the first line filled.
- R8: Entries with an index below lockBase are never overwritten by a fill, so lines held there keep hitting however many other lines pass through the segment.
- R9: When a segment's victim pointer is below lockBase, the fill goes to entry lockBase. The pointer wraps from entry 63 back to lockBase.
- R10: reqReady is 1 only when the cache is idle. A request presented while reqReady is 0 is ignored: it causes no beat and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present |
| reqAddr | input | 32 | Load byte address |
| reqReady | output | 1 | Cache idle, request accepted on this edge |
| respValid | output | 1 | Load data valid (one cycle) |
| respData | output | 32 | Load data |
| lockBase | input | 6 | Entries below this index are locked |
| memReq | output | 1 | Half-word read requested |
| memAddr | output | 32 | Byte address of requested half-word |
| memAck | input | 1 | memRdata valid, beat accepted on this edge |
| memRdata | input | 16 | Half-word read data |

## Verification
A corrupt tag, valid bit or data word shows up at the next load to that line. It appears as wrong respData two cycles after acceptance, or as a hit/miss decision flipped from what the bench expects, visible as beats that do or do not appear. A wrong victim pointer or lockBase comparison stays hidden until the segment wraps, so the bench streams 63 to 65 distinct lines through single segments and then probes the exact entry that should or should not have been replaced. Beat ordering and half-word assembly errors show on the first miss, either in the logged beat addresses or in the returned word.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } ctrlStateT;

  typedef struct packed {
    logic capture;    // latch request address
    logic startFill;  // choose victim, clear beat counter
    logic beatWrite;  // accept one memory beat
    logic fillDone;   // install tag, advance victim pointer
    logic loadResp;   // register hit data for the response
  } ctrlStrobesT;

endpackage

// File: rtl/lrc_datapath.sv
module lrc_datapath
  import lrc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int MEM_W      = 16,
  parameter int SEGS       = 8,
  parameter int WAYS       = 64,
  parameter int LINE_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobesT                  st,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [$clog2(WAYS)-1:0]      lockBase,
  input  logic [MEM_W-1:0]             memRdata,
  output logic                         hit,
  output logic                         lastBeat,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [WORD_W-1:0]            respData
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int MEM_BYTES  = MEM_W / 8;
  localparam int BPW        = WORD_W / MEM_W;
  localparam int BPW_W      = $clog2(BPW);
  localparam int BEATS      = LINE_WORDS * BPW;
  localparam int BEAT_W     = $clog2(BEATS);
  localparam int HB_SH      = $clog2(MEM_BYTES);
  localparam int WB_SH      = $clog2(WORD_BYTES);
  localparam int WIDX_W     = $clog2(LINE_WORDS);
  localparam int OFF_W      = WIDX_W + WB_SH;
  localparam int SEG_W      = $clog2(SEGS);
  localparam int WAY_W      = $clog2(WAYS);
  localparam int TAG_W      = ADDR_W - OFF_W - SEG_W;
  localparam int IDX_W      = SEG_W + WAY_W + WIDX_W;
  localparam int DEPTH      = SEGS * WAYS * LINE_WORDS;

  logic [TAG_W-1:0]  tagQ;
  logic [SEG_W-1:0]  segQ;
  logic [WIDX_W-1:0] widxQ;
  logic [BEAT_W-1:0] beatQ;
  logic [WAY_W-1:0]  victimQ;
  logic [WORD_W-1:0] wordBufQ;
  logic [WORD_W-1:0] respDataQ;

  logic [TAG_W-1:0]  tagArr   [SEGS][WAYS];
  logic [WAYS-1:0]   validArr [SEGS];
  logic [WORD_W-1:0] dataArr  [DEPTH];
  logic [WAY_W-1:0]  ptrArr   [SEGS];

  logic [WAYS-1:0]   hitVec;
  logic [WAY_W-1:0]  hitWay;
  logic [WAY_W-1:0]  victimNext;
  logic [WAY_W-1:0]  ptrCur;
  logic [WORD_W-1:0] wordNext;
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  wrIdx;
  logic              subLast;

  // tag compare across all entries of the addressed segment
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[segQ][w] && (tagArr[segQ][w] == tagQ);
  end

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  assign hit = |hitVec;

  // victim selection: skip locked entries
  assign ptrCur     = ptrArr[segQ];
  assign victimNext = (ptrCur < lockBase) ? lockBase : ptrCur;

  // beat bookkeeping and word assembly (low half arrives first)
  assign lastBeat = (beatQ == BEAT_W'(BEATS - 1));
  assign subLast  = (beatQ[BPW_W-1:0] == BPW_W'(BPW - 1));
  assign wordNext = {memRdata, wordBufQ[WORD_W-1:MEM_W]};

  assign rdIdx   = {segQ, hitWay, widxQ};
  assign wrIdx   = {segQ, victimQ, beatQ[BEAT_W-1:BPW_W]};
  assign memAddr = {tagQ, segQ, {beatQ, {HB_SH{1'b0}}}};
  assign respData = respDataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ      <= '0;
      segQ      <= '0;
      widxQ     <= '0;
      beatQ     <= '0;
      victimQ   <= '0;
      wordBufQ  <= '0;
      respDataQ <= '0;
      for (int s = 0; s < SEGS; s++) begin
        validArr[s] <= '0;
        ptrArr[s]   <= '0;
      end
    end else begin
      if (st.capture) begin
        tagQ  <= reqAddr[ADDR_W-1:OFF_W+SEG_W];
        segQ  <= reqAddr[OFF_W+SEG_W-1:OFF_W];
        widxQ <= reqAddr[OFF_W-1:WB_SH];
      end
      if (st.startFill) begin
        victimQ <= victimNext;
        beatQ   <= '0;
      end
      if (st.beatWrite) begin
        wordBufQ <= wordNext;
        beatQ    <= beatQ + 1'b1;
      end
      if (st.fillDone) begin
        validArr[segQ][victimQ] <= 1'b1;
        ptrArr[segQ] <= (victimQ == WAY_W'(WAYS - 1)) ? lockBase
                                                       : victimQ + 1'b1;
      end
      if (st.loadResp) respDataQ <= dataArr[rdIdx];
    end
  end

  // storage without reset
  always_ff @(posedge clk) begin
    if (st.fillDone) tagArr[segQ][victimQ] <= tagQ;
    if (st.beatWrite && subLast) dataArr[wrIdx] <= wordNext;
  end

  // R2
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

endmodule

// File: rtl/lrc_ctrl.sv
module lrc_ctrl
  import lrc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        lastBeat,
  input  logic        memAck,
  output logic        reqReady,
  output logic        respValid,
  output logic        memReq,
  output ctrlStrobesT st
);

  ctrlStateT stateQ, stateNext;
  logic      respValidQ;

  always_comb begin
    stateNext = stateQ;
    st        = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          st.capture = 1'b1;
          stateNext  = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          st.loadResp = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          st.startFill = 1'b1;
          stateNext    = ST_FILL;
        end
      end
      ST_FILL: begin
        if (memAck) begin
          st.beatWrite = 1'b1;
          if (lastBeat) begin
            st.fillDone = 1'b1;
            stateNext   = ST_LOOKUP;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      respValidQ <= 1'b0;
    end else begin
      stateQ     <= stateNext;
      respValidQ <= st.loadResp;
    end
  end

  assign reqReady  = (stateQ == ST_IDLE);
  assign memReq    = (stateQ == ST_FILL);
  assign respValid = respValidQ;

  // R5
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && lastBeat) |=> hit);

  // R5
  single_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

endmodule

// File: rtl/lockable_read_cache.sv
module lockable_read_cache
  import lrc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int MEM_W      = 16,
  parameter int SEGS       = 8,
  parameter int WAYS       = 64,
  parameter int LINE_WORDS = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  output logic                    reqReady,
  output logic                    respValid,
  output logic [WORD_W-1:0]       respData,
  input  logic [$clog2(WAYS)-1:0] lockBase,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memAck,
  input  logic [MEM_W-1:0]        memRdata
);

  localparam int MEM_BYTES = MEM_W / 8;

  ctrlStrobesT st;
  logic        hit;
  logic        lastBeat;

  lrc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .hit       (hit),
    .lastBeat  (lastBeat),
    .memAck    (memAck),
    .reqReady  (reqReady),
    .respValid (respValid),
    .memReq    (memReq),
    .st        (st)
  );

  lrc_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .MEM_W      (MEM_W),
    .SEGS       (SEGS),
    .WAYS       (WAYS),
    .LINE_WORDS (LINE_WORDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .reqAddr  (reqAddr),
    .lockBase (lockBase),
    .memRdata (memRdata),
    .hit      (hit),
    .lastBeat (lastBeat),
    .memAddr  (memAddr),
    .respData (respData)
  );

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !lastBeat) |=>
      (memReq && memAddr == $past(memAddr) + ADDR_W'(MEM_BYTES)));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

endmodule

// File: tb/sim_lockable_read_cache.sv
`timescale 1ns/1ps
module sim_lockable_read_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady;
  logic        respValid;
  logic [31:0] respData;
  logic [5:0]  lockBase = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [15:0] memRdata = '0;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int ackTick = 0;
  int beatCnt = 0;
  logic [31:0] beatLog [64];

  always #5 clk = ~clk;

  lockable_read_cache u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respValid(respValid), .respData(respData),
    .lockBase(lockBase), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [15:0] hw(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] expWord(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:2], 2'b00};
    return {hw(b | 32'd2), hw(b)};
  endfunction

  function automatic logic [31:0] mk(input logic [23:0] tag,
                                     input logic [2:0] seg,
                                     input logic [2:0] widx);
    return {tag, seg, widx, 2'b00};
  endfunction

  // memory model: acknowledges two cycles out of three
  always @(negedge clk) begin
    logic a;
    a = memReq && (ackTick % 3 != 2);
    ackTick++;
    memAck   <= a;
    memRdata <= hw(memAddr);
    if (a) begin
      if (beatCnt < 64) beatLog[beatCnt] = memAddr;
      beatCnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: run exceeded %0d cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReq(input logic [31:0] addr, output logic [31:0] data,
                       output int lat, output int beats);
    @(negedge clk); #1;
    while (!reqReady) begin @(negedge clk); #1; end
    reqValid = 1'b1;
    reqAddr  = addr;
    beatCnt  = 0;
    @(posedge clk); #1;
    reqValid = 1'b0;
    lat = 0;
    do begin
      @(negedge clk); #1;
      lat++;
    end while (!respValid && lat < 300);
    data  = respData;
    beats = beatCnt;
  endtask

  task automatic expectHit(input logic [31:0] addr, input string req);
    logic [31:0] d; int lat; int beats;
    doReq(addr, d, lat, beats);
    chk(beats == 0, req, "hit issued beats", beats, 0);
    chk(lat == 2, req, "hit latency", lat, 2);
    chk(d == expWord(addr), req, "hit data", d, expWord(addr));
  endtask

  task automatic expectMiss(input logic [31:0] addr, input string req);
    logic [31:0] d; int lat; int beats;
    doReq(addr, d, lat, beats);
    chk(beats == 16, req, "miss beat count", beats, 16);
    chk(d == expWord(addr), req, "miss data", d, expWord(addr));
  endtask

  task automatic fillQuiet(input logic [31:0] addr);
    logic [31:0] d; int lat; int beats;
    doReq(addr, d, lat, beats);
  endtask

  task automatic tReset();
    @(negedge clk); #1;
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    chk(respValid == 1'b0, "R1", "respValid after reset", respValid, 0);
    chk(memReq == 1'b0, "R1", "memReq after reset", memReq, 0);
  endtask

  task automatic tFirstMiss();
    logic [31:0] a, d, base; int lat; int beats;
    a = 32'h1000_0004;
    base = 32'h1000_0000;
    doReq(a, d, lat, beats);
    chk(beats == 16, "R1", "first access misses", beats, 16);
    for (int k = 0; k < 16; k++)
      chk(beatLog[k] == base + 32'(2 * k), "R3", "beat address",
          beatLog[k], base + 32'(2 * k));
    chk(d == expWord(a), "R4", "assembled word", d, expWord(a));
    chk(lat >= 19, "R5", "miss latency lower bound", lat, 19);
  endtask

  task automatic tHit();
    expectHit(32'h1000_0018, "R6");
    expectHit(32'h1000_001B, "R2");
    expectHit(32'h1000_0000, "R6");
  endtask

  task automatic tSegments();
    expectMiss(32'h1000_0024, "R2");
    expectHit(32'h1000_0004, "R2");
    expectHit(32'h1000_0038, "R2");
  endtask

  task automatic tIgnoreBusy();
    logic [31:0] a, other; int lat; int resps; int beats; logic [31:0] d;
    bit inLine;
    a = mk(24'h0077, 3'd5, 3'd6);
    other = mk(24'h0078, 3'd5, 3'd1);
    @(negedge clk); #1;
    reqValid = 1'b1; reqAddr = a; beatCnt = 0;
    @(posedge clk); #1;
    reqValid = 1'b0;
    resps = 0; d = '0;
    for (int c = 1; c < 60; c++) begin
      @(negedge clk); #1;
      if (c == 3) begin
        chk(reqReady == 1'b0, "R10", "not ready while filling", reqReady, 0);
        reqValid = 1'b1; reqAddr = other;
      end
      if (c == 8) reqValid = 1'b0;
      if (respValid) begin resps++; d = respData; end
    end
    beats = beatCnt;
    chk(resps == 1, "R10", "response count", resps, 1);
    chk(beats == 16, "R10", "beats for one fill", beats, 16);
    inLine = 1'b1;
    for (int k = 0; k < 16; k++)
      if (beatLog[k][31:5] != a[31:5]) inLine = 1'b0;
    chk(inLine, "R10", "beats stay in accepted line", beatLog[15], a);
    chk(d == expWord(a), "R5", "busy-period response data", d, expWord(a));
    doReq(other, d, lat, beats);
    chk(beats == 16, "R10", "ignored address not cached", beats, 16);
  endtask

  task automatic tRoundRobin();
    for (int i = 0; i < 64; i++) fillQuiet(mk(24'(32'h100 + i), 3'd2, 3'd0));
    expectHit(mk(24'h100, 3'd2, 3'd3), "R7");
    expectHit(mk(24'h13F, 3'd2, 3'd7), "R7");
    expectMiss(mk(24'h140, 3'd2, 3'd0), "R7");
    expectHit(mk(24'h101, 3'd2, 3'd2), "R7");
    expectMiss(mk(24'h100, 3'd2, 3'd1), "R7");
  endtask

  task automatic tLock();
    expectMiss(mk(24'h300, 3'd3, 3'd0), "R8");
    expectMiss(mk(24'h301, 3'd3, 3'd4), "R8");
    @(negedge clk); lockBase = 6'd2;
    for (int i = 0; i < 63; i++) fillQuiet(mk(24'(32'h400 + i), 3'd3, 3'd0));
    expectHit(mk(24'h300, 3'd3, 3'd5), "R8");
    expectHit(mk(24'h301, 3'd3, 3'd1), "R8");
    expectHit(mk(24'h401, 3'd3, 3'd2), "R8");
    expectMiss(mk(24'h400, 3'd3, 3'd0), "R8");
  endtask

  task automatic tSnap();
    for (int i = 0; i < 63; i++) fillQuiet(mk(24'(32'h500 + i), 3'd4, 3'd0));
    expectHit(mk(24'h501, 3'd4, 3'd6), "R9");
    expectHit(mk(24'h53E, 3'd4, 3'd3), "R9");
    expectMiss(mk(24'h500, 3'd4, 3'd0), "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tReset();
    tFirstMiss();
    tHit();
    tSegments();
    tIgnoreBusy();
    tRoundRobin();
    tLock();
    tSnap();
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule